// File: doc/BRIEF.md
# I2C Controller Interrupt Status, Mask and Clear Unit

This block collects twelve event sources from an I2C controller into a raw status vector. It also keeps a mask register and a latched record of why the last transmit abort happened. Software reads the raw view or the masked view over a simple strobed register bus. A single interrupt line is raised whenever any unmasked event is pending.

Ten of the events are sticky. Each is set by a one-cycle pulse from the bus engine or the FIFOs, and stays set until software clears it. Clearing is a side effect of a read: each sticky event has its own clear address, and one further address clears all of them at once. Bus writes never clear anything. The receive-full and transmit-empty events are level inputs. They pass straight through and no read clears them.

Reading the transmit-abort clear address also empties the abort-cause record. Software must therefore read the cause before it clears the abort event.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, all sticky status bits, the mask, the abort cause, `irq` and `rd_data` are zero.
- R2: Event bit order is 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 bus activity, 9 stop seen, 10 start seen, 11 general call. A pulse on a sticky bit sets it, and the bit stays set with no further input until it is cleared. The raw vector is read at 0x34.
- R3: A read of a per-source clear address clears only its own bit. The addresses are 0x44 (bit 0), 0x48 (1), 0x4C (3), 0x50 (5), 0x54 (6), 0x58 (7), 0x5C (8), 0x60 (9), 0x64 (10) and 0x68 (11). That read returns the bit's value from before the clear in `rd_data[0]`, with all other bits zero.
- R4: A read of 0x40 clears every sticky bit and the abort cause, and returns zero.
- R5: Bits 2 and 4 follow `evt_in[2]` and `evt_in[4]` in the same cycle, and no read clears them.
- R6: If an event pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: The mask is written at 0x30 and read back there. The masked status at 0x2C always equals raw AND mask. Writes to any other address have no effect.
- R8: `irq` is the OR of all masked status bits, delayed by one register stage.
- R9: On each transmit-abort pulse, `abrt_cause_in` is ORed into the cause record, which is read at 0x80. The bit layout of the record is: bits 0 to 4 address and data no-acknowledge, 7 start byte acknowledged, 9 start byte with restart disabled, 10 ten-bit read with restart disabled, 11 used while disabled, 12 arbitration lost. A read of 0x54 zeroes the record; a pulse arriving in that same cycle loads its own cause. The cause input is ignored when no abort pulse is present.
- R10: `rd_data` is registered and appears in the cycle after `rd_en`. Unmapped addresses read as zero. When `rd_en` is low, `rd_data` holds its value.
- R11: Reads of 0x2C, 0x30, 0x34 and 0x80 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 12 | Event pulses (sticky bits) or levels (bits 2, 4) |
| abrt_cause_in | input | 13 | Abort cause vector, valid with the abort pulse |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 12 | Write data (mask) |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives an event pulse in the same cycle as the clear read of that bit. A design that lets the clear win would lose an interrupt that arrived during service. It reads the abort cause before and after its clear, and again with a new abort arriving during the clear. A design that keeps stale causes or drops the new one returns a wrong cause word. It holds a level bit high across a global clear; a design that clears level bits would report an empty FIFO as gone. It also times `irq` against a mask write to one cycle, which catches a design with no register stage or an extra one.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NEVT   = 12;
    localparam int ABRT_W = 13;
    localparam int REG_AW = 8;
    localparam int REG_DW = 16;

    localparam int EV_RX_UNDER  = 0;
    localparam int EV_RX_OVER   = 1;
    localparam int EV_RX_FULL   = 2;
    localparam int EV_TX_OVER   = 3;
    localparam int EV_TX_EMPTY  = 4;
    localparam int EV_RD_REQ    = 5;
    localparam int EV_TX_ABRT   = 6;
    localparam int EV_RX_DONE   = 7;
    localparam int EV_ACTIVITY  = 8;
    localparam int EV_STOP_DET  = 9;
    localparam int EV_START_DET = 10;
    localparam int EV_GEN_CALL  = 11;

    localparam logic [NEVT-1:0] LEVEL_BITS =
        NEVT'((1 << EV_RX_FULL) | (1 << EV_TX_EMPTY));

    localparam int unsigned ADR_MSTAT = 'h2C;
    localparam int unsigned ADR_MASK  = 'h30;
    localparam int unsigned ADR_RAW   = 'h34;
    localparam int unsigned ADR_GCLR  = 'h40;
    localparam int unsigned ADR_CAUSE = 'h80;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MSTAT,
        SEL_MASK,
        SEL_RAW,
        SEL_CAUSE,
        SEL_CLR_ONE,
        SEL_CLR_ALL
    } rsel_e;

    // Clear address of each sticky event; zero means none.
    function automatic int unsigned clr_code(int unsigned idx);
        case (idx)
            EV_RX_UNDER:  return 'h44;
            EV_RX_OVER:   return 'h48;
            EV_TX_OVER:   return 'h4C;
            EV_RD_REQ:    return 'h50;
            EV_TX_ABRT:   return 'h54;
            EV_RX_DONE:   return 'h58;
            EV_ACTIVITY:  return 'h5C;
            EV_STOP_DET:  return 'h60;
            EV_START_DET: return 'h64;
            EV_GEN_CALL:  return 'h68;
            default:      return 0;
        endcase
    endfunction

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
    import evt_irq_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic            rd_en_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    output rsel_e           rsel_o,
    output logic [NEVT-1:0] clr_o,
    output logic            mask_we_o
);

    logic [NEVT-1:0] hit;
    logic            gclr;

    for (genvar i = 0; i < NEVT; i++) begin : g_hit
        if (clr_code(i) != 0) begin : g_has
            assign hit[i] = (addr_i == AW'(clr_code(i)));
        end else begin : g_none
            assign hit[i] = 1'b0;
        end
    end

    assign gclr = (addr_i == AW'(ADR_GCLR));

    always_comb begin
        rsel_o = SEL_NONE;
        if (|hit)                          rsel_o = SEL_CLR_ONE;
        else if (gclr)                     rsel_o = SEL_CLR_ALL;
        else if (addr_i == AW'(ADR_MSTAT)) rsel_o = SEL_MSTAT;
        else if (addr_i == AW'(ADR_MASK))  rsel_o = SEL_MASK;
        else if (addr_i == AW'(ADR_RAW))   rsel_o = SEL_RAW;
        else if (addr_i == AW'(ADR_CAUSE)) rsel_o = SEL_CAUSE;
    end

    assign clr_o     = rd_en_i ? ((hit | {NEVT{gclr}}) & ~LEVEL_BITS) : '0;
    assign mask_we_o = wr_en_i && (addr_i == AW'(ADR_MASK));

endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
    import evt_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] evt_i,
    input  logic [NEVT-1:0] clr_i,
    output logic [NEVT-1:0] raw_o,
    output logic [NEVT-1:0] cleared_o
);

    for (genvar i = 0; i < NEVT; i++) begin : g_bit
        if (LEVEL_BITS[i]) begin : g_level
            assign raw_o[i] = evt_i[i];
        end else begin : g_sticky
            logic hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hold_q <= 1'b0;
                else        hold_q <= evt_i[i] | (hold_q & ~clr_i[i]);
            end
            assign raw_o[i] = hold_q;

            a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (hold_q && !clr_i[i]) |=> hold_q);
            a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> hold_q);
            a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !evt_i[i]) |=> !hold_q);
        end
    end

    assign cleared_o = clr_i & raw_o;

endmodule

// File: rtl/evt_abort_latch.sv
module evt_abort_latch
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [ABRT_W-1:0] cause_i,
    output logic [ABRT_W-1:0] cause_o
);

    logic [ABRT_W-1:0] cause_q;
    logic [ABRT_W-1:0] base;

    assign base = clr_i ? '0 : cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cause_q <= '0;
        else if (set_i) cause_q <= base | cause_i;
        else            cause_q <= base;
    end

    assign cause_o = cause_q;

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> (cause_o == '0));
    a_r9_new_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((cause_o & $past(cause_i)) == $past(cause_i)));
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(cause_o));

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEVT-1:0]   evt_in,
    input  logic [ABRT_W-1:0] abrt_cause_in,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [NEVT-1:0]   wr_data,
    output logic [DW-1:0]     rd_data,
    output logic              irq
);

    rsel_e             rsel;
    logic [NEVT-1:0]   clr;
    logic              mask_we;
    logic [NEVT-1:0]   raw;
    logic [NEVT-1:0]   cleared;
    logic [NEVT-1:0]   mask_q;
    logic [NEVT-1:0]   masked;
    logic [ABRT_W-1:0] cause;
    logic [DW-1:0]     rd_q;
    logic              irq_q;

    evt_addr_dec #(.AW(AW)) u_dec (
        .rd_en_i   (rd_en),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .rsel_o    (rsel),
        .clr_o     (clr),
        .mask_we_o (mask_we)
    );

    evt_status_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_in),
        .clr_i     (clr),
        .raw_o     (raw),
        .cleared_o (cleared)
    );

    evt_abort_latch u_abrt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_in[EV_TX_ABRT]),
        .clr_i   (clr[EV_TX_ABRT]),
        .cause_i (abrt_cause_in),
        .cause_o (cause)
    );

    assign masked = raw & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            unique case (rsel)
                SEL_MSTAT:   rd_q <= DW'(masked);
                SEL_MASK:    rd_q <= DW'(mask_q);
                SEL_RAW:     rd_q <= DW'(raw);
                SEL_CAUSE:   rd_q <= DW'(cause);
                SEL_CLR_ONE: rd_q <= DW'(|cleared);
                default:     rd_q <= '0;
            endcase
        end
    end

    assign rd_data = rd_q;
    assign irq     = irq_q;

    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq);
    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wr_data)));
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    a_r5_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & LEVEL_BITS) == (evt_in & LEVEL_BITS));

endmodule

// File: tb/sim_evt_irq_hub.sv
module sim_evt_irq_hub;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] evt;
    logic [12:0] cause_in;
    logic        rd_en;
    logic        wr_en;
    logic [7:0]  addr;
    logic [11:0] wdata;
    logic [15:0] rdata;
    logic        irq;

    int    vectors  = 0;
    int    miscmp   = 0;
    bit    finished = 0;
    string phase    = "R1";

    int m_sticky;
    int m_mask;
    int m_cause;
    int m_rd;
    bit m_irq;

    always #10 clk = ~clk;

    evt_irq_hub u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_in        (evt),
        .abrt_cause_in (cause_in),
        .rd_en         (rd_en),
        .wr_en         (wr_en),
        .addr          (addr),
        .wr_data       (wdata),
        .rd_data       (rdata),
        .irq           (irq)
    );

    function automatic int clear_bit(int a);
        case (a)
            'h44: return 0;  'h48: return 1;  'h4C: return 3;
            'h50: return 5;  'h54: return 6;  'h58: return 7;
            'h5C: return 8;  'h60: return 9;  'h64: return 10;
            'h68: return 11;
            default: return -1;
        endcase
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk or negedge rst_n) begin
        int raw_now;
        int nxt;
        int nc;
        int b;
        if (!rst_n) begin
            m_sticky = 0; m_mask = 0; m_cause = 0; m_rd = 0; m_irq = 0;
        end else begin
            raw_now = m_sticky | (int'(evt) & 'h014);
            nxt = m_sticky;
            nc  = m_cause;
            if (rd_en) begin
                b = clear_bit(int'(addr));
                case (int'(addr))
                    'h2C: m_rd = raw_now & m_mask;
                    'h30: m_rd = m_mask;
                    'h34: m_rd = raw_now;
                    'h80: m_rd = m_cause;
                    default: m_rd = (b >= 0) ? ((raw_now >> b) & 1) : 0;
                endcase
                if (b >= 0) begin
                    nxt = nxt & ~(1 << b);
                    if (b == 6) nc = 0;
                end
                if (int'(addr) == 'h40) begin
                    nxt = 0;
                    nc  = 0;
                end
            end
            nxt = nxt | int'(evt);
            if (evt[6]) nc = nc | int'(cause_in);
            m_irq = ((raw_now & m_mask) != 0);
            if (wr_en && int'(addr) == 'h30) m_mask = int'(wdata);
            m_sticky = nxt & 'hFEB;
            m_cause  = nc;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            vectors++;
            if (rdata !== m_rd[15:0] || irq !== m_irq) begin
                miscmp++;
                $display("FAIL %s per-cycle: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                         phase, rdata, irq, m_rd[15:0], m_irq);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(int a, int exp, string tag);
        phase = tag;
        @(negedge clk);
        addr = 8'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(tag, int'(rdata), exp);
    endtask

    task automatic pulse(int bits, int cz);
        @(negedge clk);
        evt = (evt & 12'h014) | 12'(bits); cause_in = 13'(cz);
        @(negedge clk);
        evt = evt & 12'h014; cause_in = '0;
    endtask

    task automatic rd_pulse(int a, int bits, int cz, int exp, string tag);
        phase = tag;
        @(negedge clk);
        addr = 8'(a); rd_en = 1'b1;
        evt = (evt & 12'h014) | 12'(bits); cause_in = 13'(cz);
        @(negedge clk);
        rd_en = 1'b0; evt = evt & 12'h014; cause_in = '0;
        chk(tag, int'(rdata), exp);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = 8'(a); wdata = 12'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscmp++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; evt = '0; cause_in = '0;
        rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", int'(rdata), 0);
        chk("R1", int'(irq), 0);
        rst_n = 1'b1;
        rd_chk('h34, 0, "R1");
        rd_chk('h30, 0, "R1");
        rd_chk('h80, 0, "R1");
        rd_chk('h2C, 0, "R1");

        // R2 / R11: sticky set and non-destructive reads
        pulse('h00B, 0);
        rd_chk('h34, 'h00B, "R2");
        repeat (5) @(negedge clk);
        rd_chk('h34, 'h00B, "R11");
        rd_chk('h2C, 0, "R11");
        chk("R8", int'(irq), 0);

        // R7 / R8: mask and masked view
        wr('h30, 'hFFF);
        rd_chk('h30, 'hFFF, "R7");
        rd_chk('h2C, 'h00B, "R7");
        chk("R8", int'(irq), 1);
        wr('h30, 'h002);
        rd_chk('h2C, 'h002, "R7");

        // R3: per-source clear
        rd_chk('h48, 1, "R3");
        rd_chk('h34, 'h009, "R3");
        rd_chk('h48, 0, "R3");
        @(negedge clk);
        chk("R8", int'(irq), 0);

        // R5 / R4: level bit across global clear
        wr('h30, 'hFFF);
        phase = "R5";
        @(negedge clk);
        evt = 12'h004;
        rd_chk('h34, 'h00D, "R5");
        rd_chk('h40, 0, "R4");
        rd_chk('h34, 'h004, "R4");
        @(negedge clk);
        evt = '0;
        rd_chk('h34, 0, "R5");

        // R6: event beats a same-cycle clear
        pulse('h001, 0);
        rd_pulse('h44, 'h001, 0, 1, "R6");
        rd_chk('h34, 'h001, "R6");
        rd_chk('h44, 1, "R3");
        rd_chk('h34, 0, "R3");

        // R9: abort cause record
        pulse('h040, 'h0081);
        pulse('h040, 'h1000);
        rd_chk('h80, 'h1081, "R9");
        @(negedge clk);
        cause_in = 13'h1FFF;
        @(negedge clk);
        cause_in = '0;
        rd_chk('h80, 'h1081, "R9");
        rd_chk('h34, 'h040, "R9");
        rd_chk('h54, 1, "R9");
        rd_chk('h80, 0, "R9");
        rd_chk('h34, 0, "R9");
        rd_pulse('h54, 'h040, 'h0200, 0, "R9");
        rd_chk('h80, 'h0200, "R9");
        rd_chk('h34, 'h040, "R6");
        rd_chk('h40, 0, "R4");
        rd_chk('h80, 0, "R4");

        // R7: writes elsewhere ignored
        pulse('h200, 0);
        wr('h34, 'hFFF);
        wr('h2C, 'h000);
        wr('h40, 'h000);
        rd_chk('h34, 'h200, "R7");
        rd_chk('h30, 'hFFF, "R7");

        // R8: one-cycle irq latency after mask drop
        phase = "R8";
        wr('h30, 0);
        chk("R8", int'(irq), 1);
        @(negedge clk);
        chk("R8", int'(irq), 0);

        // R10: unmapped reads, hold when idle
        rd_chk('h10, 0, "R10");
        rd_chk('h7C, 0, "R10");
        rd_chk('h34, 'h200, "R10");
        repeat (3) @(negedge clk);
        chk("R10", int'(rdata), 'h200);

        // R3: every clear address in turn
        pulse('hFEB, 0);
        rd_chk('h34, 'hFEB, "R2");
        for (int a = 'h44; a <= 'h68; a += 4) begin
            rd_chk(a, 1, "R3");
        end
        rd_chk('h34, 0, "R3");

        repeat (2) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule